// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block is the configuration register file of a 32-bit parallel-bus target. It serves configuration reads and writes addressed by a dword index, with four byte enables and 32-bit write data. Read data is registered and comes back one cycle after the read strobe, together with a valid flag. The header covers dword indices 0 to 15 (byte offsets 00h to 3Ch). It holds fixed identity fields, the command and status words, the latency timer, the interrupt line and pin, a capability pointer, and up to three live base address registers (BARs).

Each BAR is set by parameters to decode either memory or I/O space, with a power-of-two window from 16 bytes to 2 GB. The block compares the incoming bus address with every live BAR and drives one hit bit per BAR. A hit also needs the matching space-enable bit in the command word. A configuration access at dword index 16 or above is handed to user logic. User logic can claim a read and supply its data. It also supplies the capability pointer value, so that extended capability structures can live outside this block.

Top module: `cfg_hdr_top`

## Requirements
- R1: A read returns its data on `cfgRdata`, with `rdValid` high, in the cycle after `cfgRd`. Index 0 reads {DEVICE_ID, VENDOR_ID}. Index 2 reads {CLASS_CODE, REV_ID}. Index 11 reads {SUBSYS_ID, SUBSYS_VID}. Index 15 reads {MAX_LAT, MIN_GNT, INT_PIN, interrupt line} from the high byte down.
- R2: Read-only fields keep their value when written. Unimplemented locations in the header read zero: index 10, index 12, index 14, and the unused bytes of index 3 (BIST, header type, cache line size).
- R3: The command word (index 1, bits 15:0) is writable only in bits 0, 1, 2, 6 and 8; all other command bits read zero. Each byte lane is written only when its byte enable is set.
- R4: Status bits 15 (parity error), 14 (system error signaled), 13 (master abort received) and 12 (target abort received) sit in index 1, bits 31:28. Each is set by a one-cycle pulse on `parErrIn`, `serrIn`, `mstAbtIn` or `tgtAbtIn`. Each is cleared by writing 1 to it with byte enable 3 set. When a pulse and a clear land in the same cycle, the set wins.
- R5: The latency timer (index 3, bits 15:8) and the interrupt line (index 15, bits 7:0) are writable, each only under its own byte enable.
- R6: BAR bits below log2 of the window size read zero. Bit 0 reads 1 for an I/O BAR and 0 for a memory BAR. Writing all ones and reading back gives the window size.
- R7: BAR slots at or above NUM_BARS, and the slots at indices 7 to 9, read zero and ignore writes.
- R8: `barHit[i]` is 1 only when three conditions hold: `busAddr` matches BAR i in its writable bits, `addrIsIo` matches the BAR's space type, and the command enable bit for that space is set (bit 0 for I/O, bit 1 for memory).
- R9: Index 13 reads `usrCapPtr` in bits 7:0, with zeros above.
- R10: An access at index 16 or above raises `usrSel` in the cycle of the strobe. Such a read returns `usrRdata` when `usrClaim` is high and zero otherwise. Such a write changes no header register.
- R11: Reset clears the command word, the status bits, the BARs, the latency timer and the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgRd | input | 1 | Configuration read strobe |
| cfgWr | input | 1 | Configuration write strobe |
| cfgDword | input | 6 | Dword index of the access |
| cfgBe | input | 4 | Byte enables for the write |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Registered read data |
| rdValid | output | 1 | Read data valid, one cycle after cfgRd |
| usrSel | output | 1 | Access at index 16 or above is for user logic |
| usrClaim | input | 1 | User logic claims the current read |
| usrRdata | input | 32 | User read data |
| usrCapPtr | input | 8 | Capability pointer value |
| parErrIn | input | 1 | Pulse: parity error detected |
| serrIn | input | 1 | Pulse: system error signaled |
| mstAbtIn | input | 1 | Pulse: master abort received |
| tgtAbtIn | input | 1 | Pulse: target abort received |
| busAddr | input | 32 | Bus address to decode |
| addrIsIo | input | 1 | Bus address is in I/O space |
| barHit | output | 3 | Per-BAR hit |

## Verification
The bench builds the block with all three BARs live. BAR0 is a 4 KB memory window, BAR1 is a 16-byte I/O window (the smallest size) and BAR2 is a 2 GB memory window (the largest size). This puts both ends of the size range and both space types in one build. With the 2 GB window, the size read-back and the address compare both come down to the single top bit. With the 16-byte I/O window, the I/O flag in bit 0 sits next to the read-only zero bits.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int ADDR_W = 6;
  localparam int NUM_SLOTS = 3;

  // dword indices whose position the bus software depends on
  localparam logic [ADDR_W-1:0] IDX_ID      = 6'd0;
  localparam logic [ADDR_W-1:0] IDX_CMDSTAT = 6'd1;
  localparam logic [ADDR_W-1:0] IDX_CLASS   = 6'd2;
  localparam logic [ADDR_W-1:0] IDX_MISC    = 6'd3;
  localparam logic [ADDR_W-1:0] IDX_BAR0    = 6'd4;
  localparam logic [ADDR_W-1:0] IDX_BAR1    = 6'd5;
  localparam logic [ADDR_W-1:0] IDX_BAR2    = 6'd6;
  localparam logic [ADDR_W-1:0] IDX_SUBSYS  = 6'd11;
  localparam logic [ADDR_W-1:0] IDX_CAP     = 6'd13;
  localparam logic [ADDR_W-1:0] IDX_INTR    = 6'd15;

  // writable command bits: io, mem, master, parity response, system error enable
  localparam logic [15:0] CMD_WMASK = 16'h0147;

  typedef struct packed {
    logic                 wrCmdStat;
    logic                 wrMisc;
    logic                 wrIntr;
    logic [NUM_SLOTS-1:0] wrBar;
    logic                 rdEn;
    logic                 userSel;
  } cfgStrobe_t;

  function automatic logic [31:0] barMask(input int unsigned lg);
    barMask = ~((32'h1 << lg) - 32'h1);
  endfunction
endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic              cfgRd,
  input  logic              cfgWr,
  input  logic [ADDR_W-1:0] cfgDword,
  output cfgStrobe_t        strb
);
  logic inUser;
  logic hdrWr;

  assign inUser = |cfgDword[ADDR_W-1:4];
  assign hdrWr  = cfgWr & ~inUser;

  always_comb begin
    strb           = '0;
    strb.rdEn      = cfgRd;
    strb.userSel   = (cfgRd | cfgWr) & inUser;
    strb.wrCmdStat = hdrWr && (cfgDword == IDX_CMDSTAT);
    strb.wrMisc    = hdrWr && (cfgDword == IDX_MISC);
    strb.wrIntr    = hdrWr && (cfgDword == IDX_INTR);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      strb.wrBar[i] = hdrWr && (cfgDword == IDX_BAR0 + ADDR_W'(i));
    end
  end
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]  REV_ID     = 8'h05,
  parameter logic [23:0] CLASS_CODE = 24'h028000,
  parameter logic [15:0] SUBSYS_VID = 16'h5E6F,
  parameter logic [15:0] SUBSYS_ID  = 16'h7081,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h02,
  parameter logic [7:0]  MAX_LAT    = 8'h03,
  parameter int          NUM_BARS   = 3,
  parameter logic [NUM_SLOTS-1:0]      BAR_IO   = 3'b010,
  parameter logic [NUM_SLOTS-1:0][4:0] BAR_LOG2 = {5'd31, 5'd4, 5'd12}
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [ADDR_W-1:0] cfgDword,
  input  logic [3:0]        cfgBe,
  input  logic [31:0]       cfgWdata,
  input  logic              usrClaim,
  input  logic [31:0]       usrRdata,
  input  logic [7:0]        usrCapPtr,
  input  logic [3:0]        evtIn,
  input  logic [31:0]       busAddr,
  input  logic              addrIsIo,
  output logic [31:0]       cfgRdata,
  output logic              rdValid,
  output logic [NUM_SLOTS-1:0] barHit,
  output logic [15:0]       cmdOut,
  output logic [3:0]        statOut
);
  logic [15:0] cmdQ;
  logic [3:0]  statQ, statNext, statClr;
  logic [7:0]  latQ, intLineQ;
  logic [31:0] rdNext, rdataQ;
  logic        rdValidQ;
  logic [NUM_SLOTS-1:0][31:0] barRd;

  // status: set pulses win over a write-one clear
  assign statClr  = (strb.wrCmdStat && cfgBe[3]) ? cfgWdata[31:28] : 4'b0000;
  assign statNext = evtIn | (statQ & ~statClr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ     <= '0;
      statQ    <= '0;
      latQ     <= '0;
      intLineQ <= '0;
      rdataQ   <= '0;
      rdValidQ <= 1'b0;
    end else begin
      if (strb.wrCmdStat && cfgBe[0]) cmdQ[7:0]  <= cfgWdata[7:0]  & CMD_WMASK[7:0];
      if (strb.wrCmdStat && cfgBe[1]) cmdQ[15:8] <= cfgWdata[15:8] & CMD_WMASK[15:8];
      statQ <= statNext;
      if (strb.wrMisc && cfgBe[1]) latQ     <= cfgWdata[15:8];
      if (strb.wrIntr && cfgBe[0]) intLineQ <= cfgWdata[7:0];
      rdValidQ <= strb.rdEn;
      if (strb.rdEn) rdataQ <= rdNext;
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bar
    if (i < NUM_BARS) begin : g_on
      localparam logic [31:0] MASK = barMask(BAR_LOG2[i]);
      logic [31:0] barQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          barQ <= '0;
        end else if (strb.wrBar[i]) begin
          for (int b = 0; b < 4; b++) begin
            if (cfgBe[b]) barQ[8*b +: 8] <= cfgWdata[8*b +: 8] & MASK[8*b +: 8];
          end
        end
      end
      assign barRd[i]  = barQ | {31'b0, BAR_IO[i]};
      assign barHit[i] = (addrIsIo == BAR_IO[i]) &&
                         (BAR_IO[i] ? cmdQ[0] : cmdQ[1]) &&
                         ((busAddr & MASK) == barQ);
    end else begin : g_off
      assign barRd[i]  = '0;
      assign barHit[i] = 1'b0;
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.userSel) begin
      rdNext = usrClaim ? usrRdata : '0;
    end else begin
      case (cfgDword)
        IDX_ID:      rdNext = {DEVICE_ID, VENDOR_ID};
        IDX_CMDSTAT: rdNext = {statQ, 12'h000, cmdQ};
        IDX_CLASS:   rdNext = {CLASS_CODE, REV_ID};
        IDX_MISC:    rdNext = {16'h0000, latQ, 8'h00};
        IDX_BAR0:    rdNext = barRd[0];
        IDX_BAR1:    rdNext = barRd[1];
        IDX_BAR2:    rdNext = barRd[2];
        IDX_SUBSYS:  rdNext = {SUBSYS_ID, SUBSYS_VID};
        IDX_CAP:     rdNext = {24'h000000, usrCapPtr};
        IDX_INTR:    rdNext = {MAX_LAT, MIN_GNT, INT_PIN, intLineQ};
        default:     rdNext = '0;
      endcase
    end
  end

  assign cfgRdata = rdataQ;
  assign rdValid  = rdValidQ;
  assign cmdOut   = cmdQ;
  assign statOut  = statQ;
endmodule

// File: rtl/cfg_hdr_top.sv
module cfg_hdr_top
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]  REV_ID     = 8'h05,
  parameter logic [23:0] CLASS_CODE = 24'h028000,
  parameter logic [15:0] SUBSYS_VID = 16'h5E6F,
  parameter logic [15:0] SUBSYS_ID  = 16'h7081,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h02,
  parameter logic [7:0]  MAX_LAT    = 8'h03,
  parameter int          NUM_BARS   = 3,
  parameter logic [2:0]      BAR_IO   = 3'b010,
  parameter logic [2:0][4:0] BAR_LOG2 = {5'd31, 5'd4, 5'd12}
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgRd,
  input  logic        cfgWr,
  input  logic [5:0]  cfgDword,
  input  logic [3:0]  cfgBe,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        rdValid,
  output logic        usrSel,
  input  logic        usrClaim,
  input  logic [31:0] usrRdata,
  input  logic [7:0]  usrCapPtr,
  input  logic        parErrIn,
  input  logic        serrIn,
  input  logic        mstAbtIn,
  input  logic        tgtAbtIn,
  input  logic [31:0] busAddr,
  input  logic        addrIsIo,
  output logic [2:0]  barHit
);
  cfgStrobe_t  strb;
  logic [15:0] cmdReg;
  logic [3:0]  statusReg;

  cfg_hdr_ctrl u_ctrl (
    .cfgRd    (cfgRd),
    .cfgWr    (cfgWr),
    .cfgDword (cfgDword),
    .strb     (strb)
  );

  cfg_hdr_regs #(
    .VENDOR_ID (VENDOR_ID),  .DEVICE_ID (DEVICE_ID), .REV_ID (REV_ID),
    .CLASS_CODE(CLASS_CODE), .SUBSYS_VID(SUBSYS_VID), .SUBSYS_ID(SUBSYS_ID),
    .INT_PIN   (INT_PIN),    .MIN_GNT   (MIN_GNT),   .MAX_LAT(MAX_LAT),
    .NUM_BARS  (NUM_BARS),   .BAR_IO    (BAR_IO),    .BAR_LOG2(BAR_LOG2)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgDword (cfgDword),
    .cfgBe    (cfgBe),
    .cfgWdata (cfgWdata),
    .usrClaim (usrClaim),
    .usrRdata (usrRdata),
    .usrCapPtr(usrCapPtr),
    .evtIn    ({parErrIn, serrIn, mstAbtIn, tgtAbtIn}),
    .busAddr  (busAddr),
    .addrIsIo (addrIsIo),
    .cfgRdata (cfgRdata),
    .rdValid  (rdValid),
    .barHit   (barHit),
    .cmdOut   (cmdReg),
    .statOut  (statusReg)
  );

  assign usrSel = strb.userSel;
endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk
  import cfg_hdr_pkg::*;
#(
  parameter int              NUM_BARS = 3,
  parameter logic [2:0]      BAR_IO   = 3'b010,
  parameter logic [2:0][4:0] BAR_LOG2 = {5'd31, 5'd4, 5'd12}
) (
  input logic        clk,
  input logic        rstN,
  input logic        cfgRd,
  input logic [5:0]  cfgDword,
  input logic        usrClaim,
  input logic [31:0] cfgRdata,
  input logic        rdValid,
  input logic [2:0]  barHit,
  input logic [15:0] cmdReg,
  input logic [3:0]  statusReg,
  input logic        parErrIn
);
  assert_rd_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgRd |=> rdValid);

  assert_par_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    parErrIn |=> statusReg[3]);

  assert_hit_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|barHit) |-> (cmdReg[0] | cmdReg[1]));

  assert_user_unclaimed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRd && (cfgDword >= 6'd16) && !usrClaim) |=> (cfgRdata == 32'h0));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    if (i < NUM_BARS) begin : g_on
      localparam logic [31:0] MASK = barMask(BAR_LOG2[i]);
      assert_bar_low_R6: assert property (@(posedge clk) disable iff (!rstN)
        (cfgRd && (cfgDword == IDX_BAR0 + 6'(i))) |=>
          ((cfgRdata & ~MASK) == {31'b0, BAR_IO[i]}));
    end
  end
endmodule

bind cfg_hdr_top cfg_hdr_chk #(
  .NUM_BARS(NUM_BARS), .BAR_IO(BAR_IO), .BAR_LOG2(BAR_LOG2)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgRd    (cfgRd),
  .cfgDword (cfgDword),
  .usrClaim (usrClaim),
  .cfgRdata (cfgRdata),
  .rdValid  (rdValid),
  .barHit   (barHit),
  .cmdReg   (cmdReg),
  .statusReg(statusReg),
  .parErrIn (parErrIn)
);

// File: tb/sim_cfg_hdr_top.sv
module sim_cfg_hdr_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgRd, cfgWr;
  logic [5:0]  cfgDword;
  logic [3:0]  cfgBe;
  logic [31:0] cfgWdata;
  logic [31:0] cfgRdata;
  logic        rdValid, usrSel, usrClaim;
  logic [31:0] usrRdata;
  logic [7:0]  usrCapPtr;
  logic        parErrIn, serrIn, mstAbtIn, tgtAbtIn;
  logic [31:0] busAddr;
  logic        addrIsIo;
  logic [2:0]  barHit;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  cfg_hdr_top #(
    .VENDOR_ID(16'h1A2B), .DEVICE_ID(16'h3C4D), .REV_ID(8'h05),
    .CLASS_CODE(24'h028000), .SUBSYS_VID(16'h5E6F), .SUBSYS_ID(16'h7081),
    .INT_PIN(8'h01), .MIN_GNT(8'h02), .MAX_LAT(8'h03),
    .NUM_BARS(3), .BAR_IO(3'b010), .BAR_LOG2({5'd31, 5'd4, 5'd12})
  ) u0 (.*);

  typedef struct packed {
    logic        isWr;
    logic [5:0]  dw;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'd0,  4'h0, 32'h0,        32'h3C4D1A2B}, // R1 ids
    '{1'b0, 6'd2,  4'h0, 32'h0,        32'h02800005}, // R1 class/rev
    '{1'b0, 6'd11, 4'h0, 32'h0,        32'h70815E6F}, // R1 subsystem
    '{1'b0, 6'd15, 4'h0, 32'h0,        32'h03020100}, // R1 R11 intr dword
    '{1'b0, 6'd3,  4'h0, 32'h0,        32'h00000000}, // R11 latency reset
    '{1'b1, 6'd0,  4'hF, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 6'd0,  4'h0, 32'h0,        32'h3C4D1A2B}, // R2 ids read-only
    '{1'b1, 6'd2,  4'hF, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 6'd2,  4'h0, 32'h0,        32'h02800005}, // R2 class read-only
    '{1'b1, 6'd1,  4'hF, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 6'd1,  4'h0, 32'h0,        32'h00000147}, // R3 writable mask
    '{1'b1, 6'd1,  4'h1, 32'h00000000, 32'h0},
    '{1'b0, 6'd1,  4'h0, 32'h0,        32'h00000100}, // R3 byte lane
    '{1'b1, 6'd3,  4'hF, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 6'd3,  4'h0, 32'h0,        32'h0000FF00}, // R5 latency, R2 others
    '{1'b1, 6'd15, 4'hF, 32'hFFFFFFA5, 32'h0},
    '{1'b0, 6'd15, 4'h0, 32'h0,        32'h030201A5}, // R5 int line
    '{1'b1, 6'd15, 4'h2, 32'h00005A5A, 32'h0},
    '{1'b0, 6'd15, 4'h0, 32'h0,        32'h030201A5}, // R5 lane 0 disabled
    '{1'b1, 6'd4,  4'hF, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 6'd4,  4'h0, 32'h0,        32'hFFFFF000}, // R6 4 KB memory
    '{1'b1, 6'd5,  4'hF, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 6'd5,  4'h0, 32'h0,        32'hFFFFFFF1}, // R6 16 B I/O
    '{1'b1, 6'd6,  4'hF, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 6'd6,  4'h0, 32'h0,        32'h80000000}, // R6 2 GB memory
    '{1'b1, 6'd4,  4'h2, 32'h00003400, 32'h0},
    '{1'b0, 6'd4,  4'h0, 32'h0,        32'hFFFF3000}, // R6 lane write
    '{1'b1, 6'd7,  4'hF, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 6'd7,  4'h0, 32'h0,        32'h00000000}, // R7 slot 3
    '{1'b0, 6'd9,  4'h0, 32'h0,        32'h00000000}, // R7 slot 5
    '{1'b0, 6'd12, 4'h0, 32'h0,        32'h00000000}, // R2 unimplemented
    '{1'b0, 6'd13, 4'h0, 32'h0,        32'h00000048}  // R9 cap pointer
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [5:0] dw, input logic [31:0] exp, input string tag,
                        output logic selSeen);
    @(negedge clk);
    cfgRd = 1'b1; cfgDword = dw;
    #1 selSeen = usrSel;
    @(negedge clk);
    cfgRd = 1'b0;
    chk({tag, " rdValid"}, {31'b0, rdValid}, 32'h1);
    chk(tag, cfgRdata, exp);
  endtask

  task automatic doWrite(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] wd,
                         output logic selSeen);
    @(negedge clk);
    cfgWr = 1'b1; cfgDword = dw; cfgBe = be; cfgWdata = wd;
    #1 selSeen = usrSel;
    @(negedge clk);
    cfgWr = 1'b0; cfgBe = 4'h0;
  endtask

  task automatic hitChk(input logic [31:0] a, input logic io, input logic [2:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; addrIsIo = io;
    #1 chk(tag, {29'b0, barHit}, {29'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic sel;
    rstN = 1'b0; cfgRd = 0; cfgWr = 0; cfgDword = 0; cfgBe = 0; cfgWdata = 0;
    usrClaim = 0; usrRdata = 0; usrCapPtr = 8'h48;
    parErrIn = 0; serrIn = 0; mstAbtIn = 0; tgtAbtIn = 0; busAddr = 0; addrIsIo = 0;
    repeat (3) @(negedge clk);
    #1 chk("R1 rdValid idle after reset", {31'b0, rdValid}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWr) doWrite(VEC[i].dw, VEC[i].be, VEC[i].wd, sel);
      else doRead(VEC[i].dw, VEC[i].exp, $sformatf("R%0d vector %0d", 0, i), sel);
    end

    // R4 status set by pulses, write-one-to-clear, set beats clear
    @(negedge clk); parErrIn = 1; @(negedge clk); parErrIn = 0;
    doRead(6'd1, 32'h80000100, "R4 parity set", sel);
    @(negedge clk); serrIn = 1; mstAbtIn = 1; tgtAbtIn = 1;
    @(negedge clk); serrIn = 0; mstAbtIn = 0; tgtAbtIn = 0;
    doRead(6'd1, 32'hF0000100, "R4 all set", sel);
    doWrite(6'd1, 4'h8, 32'h80000000, sel);
    doRead(6'd1, 32'h70000100, "R4 clear bit15", sel);
    doWrite(6'd1, 4'h4, 32'hF0FF0000, sel);
    doRead(6'd1, 32'h70000100, "R4 lane3 disabled", sel);
    @(negedge clk);
    cfgWr = 1; cfgDword = 6'd1; cfgBe = 4'h8; cfgWdata = 32'h40000000; serrIn = 1;
    @(negedge clk);
    cfgWr = 0; cfgBe = 0; serrIn = 0;
    doRead(6'd1, 32'h70000100, "R4 set wins", sel);
    doWrite(6'd1, 4'h8, 32'hF0000000, sel);
    doRead(6'd1, 32'h00000100, "R4 clear all", sel);

    // R8 hit decode
    doWrite(6'd4, 4'hF, 32'h12345000, sel);
    doWrite(6'd5, 4'hF, 32'h0000C010, sel);
    doRead(6'd5, 32'h0000C011, "R6 io readback", sel);
    hitChk(32'h12345ABC, 1'b0, 3'b000, "R8 mem disabled");
    doWrite(6'd1, 4'h1, 32'h00000002, sel);
    hitChk(32'h12345ABC, 1'b0, 3'b001, "R8 bar0 hit");
    hitChk(32'h12346000, 1'b0, 3'b000, "R8 bar0 miss");
    hitChk(32'h80000010, 1'b0, 3'b100, "R8 bar2 hit");
    hitChk(32'h0000C01F, 1'b1, 3'b000, "R8 io disabled");
    doWrite(6'd1, 4'h1, 32'h00000003, sel);
    hitChk(32'h0000C01F, 1'b1, 3'b010, "R8 bar1 hit");
    hitChk(32'h0000C020, 1'b1, 3'b000, "R8 bar1 miss");
    hitChk(32'h12345ABC, 1'b1, 3'b000, "R8 space mismatch");

    // R10 user range
    usrClaim = 1; usrRdata = 32'hDEADBEEF;
    doRead(6'd16, 32'hDEADBEEF, "R10 claimed read", sel);
    chk("R10 usrSel on read", {31'b0, sel}, 32'h1);
    usrClaim = 0;
    doRead(6'd63, 32'h00000000, "R10 unclaimed read", sel);
    doWrite(6'd17, 4'hF, 32'hFFFFFFFF, sel);
    chk("R10 usrSel on write", {31'b0, sel}, 32'h1);
    doRead(6'd1, 32'h00000103, "R10 header untouched", sel);
    chk("R10 usrSel low in header", {31'b0, sel}, 32'h0);

    // R11 reset
    @(negedge clk); rstN = 0; @(negedge clk); rstN = 1;
    doRead(6'd1, 32'h00000000, "R11 cmd/status", sel);
    doRead(6'd4, 32'h00000000, "R11 bar0", sel);
    doRead(6'd3, 32'h00000000, "R11 latency", sel);
    doRead(6'd15, 32'h03020100, "R11 int line", sel);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule